// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge Interrupts

This block is a 32-pin general-purpose I/O port that software reaches through a small register bus. Each pin can be an input or an output, and an output pin can be push-pull or drive-low-only (open-drain). A data register sets the values that output pins drive. A read of that register returns the driven value for output pins and the synchronized pad level for input pins, so read-back stays correct even when the line is open-drain or contended.

Every pin has an event latch that records an edge on its synchronized level. A per-pin sense bit selects whether only falling edges count or both edges count. Software clears events by writing ones to the event register. A mask register gates the events onto a single interrupt line.

Pin n sits at bit 31-n of every register and of every pin vector, so pin 0 is the most significant bit. The bus has no back-pressure. A request is accepted in every cycle in which `req_valid` is high. Write data takes effect at that clock edge. Read data returns exactly one cycle later, marked by `rsp_valid`.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads zero. All pins are inputs (`pin_oe` = 0), push-pull, masked, with no event pending, and `irq` is low.
- R2: Register offsets are as follows: direction 0x00, drive-mode 0x04, data 0x08, event 0x0C, mask 0x10 and sense 0x14. A direction bit of 1 makes that pin an output, and `pin_out` carries the data bit for push-pull outputs.
- R3: A drive-mode bit of 1 makes the pin open-drain. `pin_out` is then 0, and `pin_oe` is high only while the pin is an output whose data bit is 0.
- R4: A read of the data register returns, for each bit, the data register bit if the direction bit is 1, and otherwise the pin level after the synchronizer.
- R5: Pin n maps to bit 31-n in every register and pin vector, so an edge on pin 0 sets event bit 31 (0x80000000).
- R6: With sense bit 1, only a falling edge of the synchronized pin sets that pin's event bit, and a rising edge is ignored.
- R7: With sense bit 0, both rising and falling edges set the event bit.
- R8: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. A write never sets an event bit. Writing all ones clears every event.
- R9: If an edge and a clearing write hit the same event bit in the same cycle, the edge wins and the bit stays set.
- R10: `irq` is high exactly when the bitwise AND of the event and mask registers is non-zero.
- R11: `rsp_valid` pulses one cycle after each accepted read. Reads of unmapped offsets (0x18, 0x1C) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present, accepted the same cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid when rsp_valid is high |
| rsp_valid | output | 1 | Read response strobe, one cycle after a read request |
| pin_in | input | 32 | Pad input levels, bit 31-n for pin n |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check several rules on every cycle. Output enables never cover input pins. An open-drain pin never drives while its data bit is 1. The interrupt line always equals the OR of the masked events. An edge seen by the detector is always held in the event register on the next cycle, whatever a clearing write does. An event bit never appears without an edge, and a read response always follows its request by one cycle. Other behaviour can only be shown by the bench's scenarios: the choice between falling-only and both-edge sensing, the mixed read-back of driven and sampled bits, the bit-reversed pin numbering, and a clearing write that lands in the same cycle as a new edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NPINS  = 32;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_ODM  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_DAT  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_EVT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_MSK  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_SNS  = 5'h14;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] fall_only,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] hit,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall, clr;

  assign rise = ~prev_q & lvl;
  assign fall = prev_q & ~lvl;
  assign hit  = fall | (rise & ~fall_only);
  assign clr  = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= lvl;
      evt_q  <= (evt_q & ~clr) | hit;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = NPINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [W-1:0]      req_wdata,
  input  logic [W-1:0]      lvl,
  input  logic [W-1:0]      evt_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      odm_q,
  output logic [W-1:0]      dat_q,
  output logic [W-1:0]      msk_q,
  output logic [W-1:0]      sns_q,
  output logic              clr_en,
  output logic [W-1:0]      clr_mask,
  output logic [W-1:0]      rd_data,
  output logic              rsp_valid
);
  logic         wr, rd;
  logic [W-1:0] rd_mux;

  assign wr       = req_valid & req_write;
  assign rd       = req_valid & ~req_write;
  assign clr_en   = wr && (req_addr == OFF_EVT);
  assign clr_mask = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      odm_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      sns_q <= '0;
    end else if (wr) begin
      case (req_addr)
        OFF_DIR: dir_q <= req_wdata;
        OFF_ODM: odm_q <= req_wdata;
        OFF_DAT: dat_q <= req_wdata;
        OFF_MSK: msk_q <= req_wdata;
        OFF_SNS: sns_q <= req_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (req_addr)
      OFF_DIR: rd_mux = dir_q;
      OFF_ODM: rd_mux = odm_q;
      OFF_DAT: rd_mux = (dir_q & dat_q) | (~dir_q & lvl);
      OFF_EVT: rd_mux = evt_q;
      OFF_MSK: rd_mux = msk_q;
      OFF_SNS: rd_mux = sns_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rd_data   <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NPINS-1:0]  req_wdata,
  output logic [NPINS-1:0]  rd_data,
  output logic              rsp_valid,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] lvl, hit, evt_q;
  logic [NPINS-1:0] dir_q, odm_q, dat_q, msk_q, sns_q, clr_mask;
  logic             clr_en;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
  );

  gpio_evt #(.W(NPINS)) u_evt (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .fall_only(sns_q),
    .clr_en(clr_en), .clr_mask(clr_mask), .hit(hit), .evt_q(evt_q)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .lvl(lvl), .evt_q(evt_q),
    .dir_q(dir_q), .odm_q(odm_q), .dat_q(dat_q), .msk_q(msk_q), .sns_q(sns_q),
    .clr_en(clr_en), .clr_mask(clr_mask),
    .rd_data(rd_data), .rsp_valid(rsp_valid)
  );

  // Open-drain bits never drive high: they pull low only when data is 0.
  assign pin_out = dat_q & ~odm_q;
  assign pin_oe  = dir_q & ~(odm_q & dat_q);
  assign irq     = |(evt_q & msk_q);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_write,
  input logic         rsp_valid,
  input logic [W-1:0] pin_oe,
  input logic         irq,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] odm_q,
  input logic [W-1:0] dat_q,
  input logic [W-1:0] msk_q,
  input logic [W-1:0] evt_q,
  input logic [W-1:0] hit
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2: only output pins are ever enabled
  a_r2_oe_outputs_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_q) == '0);

  // R3: an open-drain pin with data 1 releases the line
  a_r3_od_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & odm_q & dat_q) == '0);

  // R10: interrupt tracks masked events
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((evt_q & msk_q) != '0));

  // R9: a detected edge is always held on the next cycle
  a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((evt_q & $past(hit)) == $past(hit)));

  // R8: no event bit appears without an edge
  a_r8_no_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((evt_q & ~$past(evt_q) & ~$past(hit)) == '0));

  // R11: read response one cycle after the request
  a_r11_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rsp_valid == $past(req_valid && !req_write)));
endmodule

bind gpio_port gpio_port_chk #(.W(gpio_pkg::NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .pin_oe(pin_oe), .irq(irq), .dir_q(dir_q),
  .odm_q(odm_q), .dat_q(dat_q), .msk_q(msk_q), .evt_q(evt_q), .hit(hit)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, pin_in = '0;
  logic [31:0] rd_data, pin_out, pin_oe;
  logic        rsp_valid, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // columns: dir, drive-mode, data, pin_in, exp oe, exp out, exp data read
  localparam logic [31:0] VEC [4][7] = '{
    '{32'hFFFF0000, 32'h00000000, 32'h12345678, 32'h0000ABCD,
      32'hFFFF0000, 32'h12345678, 32'h1234ABCD},
    '{32'hF0F0F0F0, 32'hFF00FF00, 32'hAAAAAAAA, 32'h55555555,
      32'h50F050F0, 32'h00AA00AA, 32'hA5A5A5A5},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000FFFF, 32'h00000000,
      32'hFFFF0000, 32'h00000000, 32'h0000FFFF},
    '{32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'hC0000001,
      32'h00000000, 32'hFFFFFFFF, 32'hC0000001}
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Called at a negedge; request sampled at the next posedge.
  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d, output logic v);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rd_data; v = rsp_valid;
  endtask

  task automatic read_check(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d; logic v;
    bus_read(a, d, v);
    check(req, {31'd0, v}, 32'd1);
    check(req, d, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check("R1 oe", pin_oe, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    check("R1 rsp idle", {31'd0, rsp_valid}, 32'h0);
    read_check("R1 dir", 5'h00, 32'h0);
    read_check("R1 odm", 5'h04, 32'h0);
    read_check("R1 evt", 5'h0C, 32'h0);
    read_check("R1 msk", 5'h10, 32'h0);
    read_check("R1 sns", 5'h14, 32'h0);

    // R2 R3 R4: vector table
    for (int i = 0; i < 4; i++) begin
      bus_write(5'h00, VEC[i][0]);
      bus_write(5'h04, VEC[i][1]);
      bus_write(5'h08, VEC[i][2]);
      pin_in = VEC[i][3];
      settle();
      check("R2/R3 oe", pin_oe, VEC[i][4]);
      check("R2/R3 out", pin_out, VEC[i][5]);
      read_check("R4 data readback", 5'h08, VEC[i][6]);
    end

    // back to quiet state
    pin_in = '0;
    bus_write(5'h00, 32'h0);
    bus_write(5'h04, 32'h0);
    settle();
    bus_write(5'h0C, 32'hFFFFFFFF);
    read_check("R8 clear all", 5'h0C, 32'h0);

    // R11: unmapped offsets
    read_check("R11 unmapped read", 5'h18, 32'h0);
    bus_write(5'h1C, 32'hFFFFFFFF);
    read_check("R11 unmapped write dir", 5'h00, 32'h0);
    read_check("R11 unmapped write msk", 5'h10, 32'h0);

    // R6: pin 0 (bit 31) falling only
    bus_write(5'h14, 32'h80000000);
    pin_in[31] = 1; settle();
    read_check("R6 rise ignored", 5'h0C, 32'h0);
    pin_in[31] = 0; settle();
    read_check("R6 R5 fall latched on bit 31", 5'h0C, 32'h80000000);
    check("R10 masked irq low", {31'd0, irq}, 32'h0);
    bus_write(5'h10, 32'h80000000);
    check("R10 unmasked irq high", {31'd0, irq}, 32'h1);

    // R7: pin 31 (bit 0) both edges
    pin_in[0] = 1; settle();
    read_check("R7 rise latched", 5'h0C, 32'h80000001);

    // R8: write-one-to-clear
    bus_write(5'h0C, 32'h00000001);
    read_check("R8 clear one bit", 5'h0C, 32'h80000000);
    bus_write(5'h0C, 32'h00000000);
    read_check("R8 zeros keep", 5'h0C, 32'h80000000);
    bus_write(5'h0C, 32'hFFFFFFFF);
    read_check("R8 all ones clear", 5'h0C, 32'h0);
    check("R10 irq low after clear", {31'd0, irq}, 32'h0);

    pin_in[0] = 0; settle();
    read_check("R7 fall latched", 5'h0C, 32'h00000001);
    bus_write(5'h0C, 32'hFFFFFFFF);

    // R9: edge and clear in the same cycle
    pin_in[0] = 1;
    @(negedge clk);
    @(negedge clk);
    bus_write(5'h0C, 32'h00000001);
    read_check("R9 edge wins over clear", 5'h0C, 32'h00000001);
    bus_write(5'h10, 32'h00000001);
    check("R10 irq on bit 0", {31'd0, irq}, 32'h1);
    bus_write(5'h0C, 32'h00000001);
    read_check("R9 later clear works", 5'h0C, 32'h0);

    // R1: reset again clears everything
    bus_write(5'h00, 32'hFFFFFFFF);
    pin_in = '0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 oe after reset", pin_oe, 32'h0);
    bus_read(5'h00, d, v);
    check("R1 dir after reset", d, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule